// File: doc/BRIEF.md
# Four-Channel Phase-Programmable PWM Generator

This block produces four pulse-width modulated waveforms from one shared 16-bit up-counter. A programmable terminal count fixes the common period. Each channel holds two 16-bit compare points. One marks the counter value where the pulse starts and the other marks where it ends, so software places every pulse anywhere in the period with any width. Each channel drives a true line and its complement, which gives eight lines in all. Each channel can be switched off on its own.

Software programs the block through an 8-bit write strobe with an address, and can read every register back. The terminal count and the compare points pass through a shadow stage. New values reach the counter and the channels only when the counter returns to zero, so a period in progress always finishes with the settings it started with.

Each channel runs a small state machine with three states. CH_OFF is the disabled state. CH_LOW is the enabled state with the output low. CH_HIGH is the enabled state with the output high. The transitions are as follows:
- OFF_TO_LOW is taken when the enable bit is set.
- LOW_TO_HIGH is taken when the counter equals the start point and the start and end points differ.
- HIGH_TO_LOW is taken when the counter equals the end point, or when the start and end points are equal.
- ANY_TO_OFF is taken when the enable bit is cleared.

Top module: `multi_pwm`

## Requirements
- R1: The counter counts up from 0 and returns to 0 after it holds the active terminal count T. The period is therefore T+1 clocks, and it is the same for all four channels.
- R2: A channel's true output rises in the cycle after the counter holds that channel's start point. The delay between the rising edges of two channels equals the difference of their start points, modulo the period.
- R3: A pulse lasts (end - start) mod period clocks, counted in whole clock cycles. This includes the case where the start point is above the end point, so the pulse spans the wrap.
- R4: A channel whose start point equals its end point keeps its true output low for the whole period.
- R5: On every clock cycle, each complementary output is the logical inverse of its true output.
- R6: A channel whose enable bit is clear drives its true output at 0 and its complementary output at 1. Channel i is enabled by bit i of the register at address 02h.
- R7: When a channel is enabled, it starts in the low state. It does not go high until the counter next reaches its start point, even when the enable arrives during the span where a pulse would be high.
- R8: Writes to the terminal count or to the compare points take effect only when the counter wraps to 0. A pulse that is already running ends at the old end point.
- R9: Register map:
  - The terminal count is at 00h (low byte) and 01h (high byte).
  - The enables are at 02h, bits 3:0. Bits 7:4 read as 0.
  - Channel i has its start point at 04h+4i (low byte) and 05h+4i (high byte), and its end point at 06h+4i (low byte) and 07h+4i (high byte).
  - Every register resets to 00h and reads back the value written to it.
  - Addresses that are not mapped read as 00h and ignore writes.
- R10: During and right after reset, all true outputs are 0 and all complementary outputs are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the register selected by addr (combinational) |
| pwm_out | output | 4 | True PWM outputs, one per channel |
| pwm_out_n | output | 4 | Complementary PWM outputs |

## Verification
The bench measures pulse widths, periods and edge-to-edge delays directly at the outputs. It aims at the corner cases where a design is most likely to go wrong:
- A pulse that spans the counter wrap would measure short or be missing if the compare logic assumed the start point is below the end point.
- A channel with equal compare points would emit a one-cycle glitch if that case were not pinned low.
- A channel enabled halfway through its pulse span would show a truncated pulse if it did not start from the low state.
- An end point rewritten in the middle of a pulse would change the width of the pulse already in flight if values took effect at once instead of at the wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Per-channel waveform state
    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_LOW  = 2'd1,
        CH_HIGH = 2'd2
    } ch_state_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    output logic [CW-1:0]            reload_q,
    output logic [NCH-1:0]           en_q,
    output logic [NCH-1:0][CW-1:0]   set_q,
    output logic [NCH-1:0][CW-1:0]   clr_q
);

    localparam int NB        = CW / 8;
    localparam int RELOAD_AD = 0;
    localparam int EN_AD     = NB;
    localparam int CH_BASE   = 2 * NB;
    localparam int CH_STRIDE = 2 * NB;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            en_q     <= '0;
            set_q    <= '0;
            clr_q    <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (addr == AW'(RELOAD_AD + b))
                    reload_q[b*8 +: 8] <= wdata;
            end
            if (addr == AW'(EN_AD))
                en_q <= wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                for (int b = 0; b < NB; b++) begin
                    if (addr == AW'(CH_BASE + i*CH_STRIDE + b))
                        set_q[i][b*8 +: 8] <= wdata;
                    if (addr == AW'(CH_BASE + i*CH_STRIDE + NB + b))
                        clr_q[i][b*8 +: 8] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr == AW'(RELOAD_AD + b))
                rdata = reload_q[b*8 +: 8];
        end
        if (addr == AW'(EN_AD))
            rdata[NCH-1:0] = en_q;
        for (int i = 0; i < NCH; i++) begin
            for (int b = 0; b < NB; b++) begin
                if (addr == AW'(CH_BASE + i*CH_STRIDE + b))
                    rdata = set_q[i][b*8 +: 8];
                if (addr == AW'(CH_BASE + i*CH_STRIDE + NB + b))
                    rdata = clr_q[i][b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CW-1:0]            reload_prog,
    input  logic [NCH-1:0][CW-1:0]   set_prog,
    input  logic [NCH-1:0][CW-1:0]   clr_prog,
    output logic [CW-1:0]            cnt,
    output logic [CW-1:0]            reload_act,
    output logic [NCH-1:0][CW-1:0]   set_act,
    output logic [NCH-1:0][CW-1:0]   clr_act
);

    logic wrap;
    assign wrap = (cnt == reload_act);

    // Counter plus shadow copies, refreshed only at the period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            reload_act <= '0;
            set_act    <= '0;
            clr_act    <= '0;
        end else if (wrap) begin
            cnt        <= '0;
            reload_act <= reload_prog;
            set_act    <= set_prog;
            clr_act    <= clr_prog;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R1: return to zero after the terminal count
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == reload_act) |=> (cnt == '0));

    // R1: single-step increment inside the period
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != reload_act) |=> (cnt == $past(cnt) + CW'(1)));

    // R8: active settings frozen mid-period
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != reload_act) |=> ($stable(reload_act) && $stable(set_act) && $stable(clr_act)));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] set_v,
    input  logic [CW-1:0] clr_v,
    output logic          out,
    output logic          out_n
);

    ch_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = CH_OFF;                               // ANY_TO_OFF
        end else begin
            unique case (state_q)
                CH_OFF:  state_d = CH_LOW;                  // OFF_TO_LOW
                CH_LOW:  if (cnt == set_v && set_v != clr_v)
                             state_d = CH_HIGH;             // LOW_TO_HIGH
                CH_HIGH: if (cnt == clr_v || set_v == clr_v)
                             state_d = CH_LOW;              // HIGH_TO_LOW
                default: state_d = CH_OFF;
            endcase
        end
    end

    always_comb begin
        out   = (state_q == CH_HIGH);
        out_n = ~out;
    end

    // R2 / R4: a rise only follows a start-point match with distinct points
    a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out) |-> ($past(cnt) == $past(set_v) && $past(set_v) != $past(clr_v)));

    // R3: a fall follows an end-point match, a disable, or equal points
    a_r3_fall_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out) |-> (!$past(en) || $past(cnt) == $past(clr_v) || $past(set_v) == $past(clr_v)));

    // R6: disabled channel low on the next cycle
    a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out);

    // R7: freshly enabled channel starts low
    a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> !out);

endmodule

// File: rtl/multi_pwm.sv
module multi_pwm #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] pwm_out_n
);

    logic [CW-1:0]           reload_q, reload_act, cnt;
    logic [NCH-1:0]          en_q;
    logic [NCH-1:0][CW-1:0]  set_q, clr_q, set_act, clr_act;

    pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .reload_q (reload_q),
        .en_q     (en_q),
        .set_q    (set_q),
        .clr_q    (clr_q)
    );

    pwm_timebase #(.NCH(NCH), .CW(CW)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_prog (reload_q),
        .set_prog    (set_q),
        .clr_prog    (clr_q),
        .cnt         (cnt),
        .reload_act  (reload_act),
        .set_act     (set_act),
        .clr_act     (clr_act)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_q[g]),
            .cnt   (cnt),
            .set_v (set_act[g]),
            .clr_v (clr_act[g]),
            .out   (pwm_out[g]),
            .out_n (pwm_out_n[g])
        );
    end

endmodule

// File: tb/tb_multi_pwm.sv
module tb_multi_pwm;

    localparam int K_WIDTH  = 0;
    localparam int K_COMPL  = 1;
    localparam int K_NHIGH  = 2;
    localparam int K_PHASE  = 3;
    localparam int K_PERIOD = 4;

    typedef struct {
        int    kind;
        int    ch;
        int    chb;
        int    exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [4:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [3:0] pwm_out, pwm_out_n;

    int    nchk = 0;
    int    nfail = 0;
    int    cyc = 0;
    int    cur_p = 1;
    item_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    multi_pwm dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .pwm_out   (pwm_out),
        .pwm_out_n (pwm_out_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input int a, input int v);
        wr(a, v & 8'hFF);
        wr(a + 1, (v >> 8) & 8'hFF);
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 5'(a);
        @(negedge clk);
        d = int'(rdata);
    endtask

    task automatic wait_rise(input int ch, output int t);
        logic prev;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
        t = cyc;
    endtask

    task automatic wait_fall(input int ch, output int t);
        do @(negedge clk); while (pwm_out[ch]);
        t = cyc;
    endtask

    task automatic push(input int kind, input int ch, input int chb, input int exp, input string tag);
        item_t it;
        it.kind = kind; it.ch = ch; it.chb = chb; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // Monitor: pops expected items and measures them at the outputs
    initial begin
        forever begin
            item_t it;
            int acc, t0, t1;
            wait (sbq.size() != 0);
            it  = sbq[0];
            acc = 0;
            case (it.kind)
                K_WIDTH: for (int k = 0; k < cur_p; k++) begin
                    @(negedge clk);
                    if (pwm_out[it.ch]) acc++;
                end
                K_COMPL: for (int k = 0; k < cur_p; k++) begin
                    @(negedge clk);
                    if (pwm_out_n[it.ch] == pwm_out[it.ch]) acc++;
                end
                K_NHIGH: for (int k = 0; k < cur_p; k++) begin
                    @(negedge clk);
                    if (pwm_out_n[it.ch]) acc++;
                end
                K_PHASE: begin
                    wait_rise(it.ch, t0);
                    wait_rise(it.chb, t1);
                    acc = t1 - t0;
                end
                default: begin
                    wait_rise(it.ch, t0);
                    wait_rise(it.ch, t1);
                    acc = t1 - t0;
                end
            endcase
            chk(it.tag, acc, it.exp);
            void'(sbq.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Driver
    initial begin
        int d, t0, t1, hi;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 true outputs in reset", int'(pwm_out), 0);
        chk("R10 complement outputs in reset", int'(pwm_out_n), 15);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 true outputs after reset", int'(pwm_out), 0);
        chk("R10 complement outputs after reset", int'(pwm_out_n), 15);

        // R9: reset values and readback
        for (int a = 0; a < 20; a++) begin
            rd(a, d);
            chk($sformatf("R9 reset value addr %0d", a), d, 0);
        end
        wr(7, 8'hA5);  rd(7, d); chk("R9 readback end hi ch0", d, 8'hA5);
        wr(2, 8'hFF);  rd(2, d); chk("R9 enable upper bits zero", d, 8'h0F);
        wr(3, 8'h77);  rd(3, d); chk("R9 unmapped 03h", d, 0);
        rd(31, d);     chk("R9 unmapped 1Fh", d, 0);
        wr(2, 0); wr(7, 0);

        // Config A: period 100
        wr16(0, 99);
        wr16(4, 10);  wr16(6, 40);
        wr16(8, 25);  wr16(10, 85);
        wr16(12, 80); wr16(14, 20);
        wr16(16, 50); wr16(18, 50);
        wr(2, 8'h0F);
        cur_p = 100;
        repeat (250) @(negedge clk);
        push(K_PERIOD, 0, 0, 100, "R1 period reload 99");
        push(K_WIDTH, 0, 0, 30, "R3 width ch0 10..40");
        push(K_WIDTH, 1, 0, 60, "R3 width ch1 25..85");
        push(K_WIDTH, 2, 0, 40, "R3 width ch2 wrap 80..20");
        push(K_WIDTH, 3, 0, 0,  "R4 equal points ch3 low");
        push(K_PHASE, 0, 1, 15, "R2 phase ch0 to ch1");
        push(K_PHASE, 1, 2, 55, "R2 phase ch1 to ch2");
        for (int c = 0; c < 4; c++) push(K_COMPL, c, 0, 0, "R5 complement");
        drain();

        // R6: disable ch1
        wr(2, 8'h0D);
        repeat (5) @(negedge clk);
        push(K_WIDTH, 1, 0, 0,   "R6 disabled true output low");
        push(K_NHIGH, 1, 0, 100, "R6 disabled complement high");
        push(K_WIDTH, 0, 0, 30,  "R6 other channel unaffected");
        drain();

        // R7: enable during pulse span
        wr16(8, 10); wr16(10, 40);
        repeat (250) @(negedge clk);
        wait_rise(0, t0);
        wr(2, 8'h0F);
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out[1]) hi++;
        end
        chk("R7 no pulse right after enable", hi, 0);
        repeat (150) @(negedge clk);
        push(K_WIDTH, 1, 0, 30, "R7 full pulse next period");
        drain();

        // R8 and R1: longer period, mid-pulse end-point rewrite
        wr16(0, 199);
        wr16(6, 110);
        cur_p = 200;
        repeat (500) @(negedge clk);
        push(K_PERIOD, 0, 0, 200, "R1 period reload 199");
        drain();
        wait_rise(0, t0);
        wr(6, 150);
        wait_fall(0, t1);
        chk("R8 running pulse keeps old end", t1 - t0, 100);
        wait_rise(0, t0);
        wait_fall(0, t1);
        chk("R8 new end after wrap", t1 - t0, 140);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule